// File: doc/BRIEF.md
# Supply and Temperature Fault Supervisor

This block watches two digitized sensor streams, the supply voltage and the die temperature, and keeps one hysteretic fault state for each. It reads a new pair of codes each time the sample-valid strobe is high. The supply state marks low supply. The temperature state marks overheating. Each state has a trip threshold and a hysteresis width. Both are configuration inputs, so the assert and release points sit apart and noise near a threshold cannot make the state chatter.

The two states drive one registered disable line that turns off every power channel at once. They are also merged with the per-channel overcurrent flags into one active-low diagnostic. That diagnostic is an open-drain drive-low enable: the block only ever pulls the line low or releases it, and a pull-up outside the block gives the high level, so several supervisors can share one wire. The low-supply state starts asserted after reset and the overheat state starts clear. The channels therefore stay off until a valid supply sample above the threshold arrives.

Top module: `sup_fault_monitor`

## Requirements
- R1: While reset is held, and in the cycle after it, low-supply is active, overheat is inactive, the channel disable is high and the diagnostic pulls low.
- R2: Low-supply clears on a strobed supply code strictly greater than the supply trip code. A code equal to the trip code does not clear it.
- R3: Low-supply sets again only on a strobed supply code strictly less than the trip code minus the supply hysteresis. Codes inside the band between those two points leave the state unchanged.
- R4: Overheat sets on a strobed temperature code strictly greater than the temperature trip code. A code equal to the trip code does not set it.
- R5: Overheat clears only on a strobed temperature code strictly less than the trip code minus the temperature hysteresis. Codes inside that band leave the state unchanged.
- R6: Each fault state changes only on a clock edge at which the sample-valid strobe is high. Sample codes presented while the strobe is low are ignored.
- R7: The channel disable output is high in the cycle after low-supply or overheat is active, and low in the cycle after both are inactive. Overcurrent flags have no effect on it.
- R8: The diagnostic pulls low in the cycle after any of low-supply, overheat or any one of the four channel overcurrent flags is present. Otherwise it is released.
- R9: When a hysteresis width exceeds its trip code, the lower point saturates at zero. Low-supply then never re-asserts and overheat never clears.
- R10: The fault states are updated in the clock edge that samples the strobe and appear on the state outputs after that edge. The disable and diagnostic outputs follow one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | Sample-valid strobe for both codes |
| vsup_code | input | 12 | Unsigned supply voltage code |
| temp_code | input | 12 | Unsigned die temperature code |
| uv_trip_code | input | 12 | Supply threshold that releases low-supply |
| uv_hyst_code | input | 12 | Supply hysteresis width |
| ot_trip_code | input | 12 | Temperature threshold that asserts overheat |
| ot_hyst_code | input | 12 | Temperature hysteresis width |
| chan_ovc | input | 4 | Per-channel overcurrent flags, bit n for channel n |
| uv_active | output | 1 | Low-supply state |
| ot_active | output | 1 | Overheat state |
| chan_off | output | 1 | Global disable for all channels |
| diag_pull_low | output | 1 | Drive-low enable for the shared diagnostic line |

## Verification
A wrong fault state first shows on uv_active or ot_active right after the strobed edge. It reaches chan_off and the shared diagnostic line one cycle later. The bench ramps both codes through the whole code range, first upward and then downward, under several threshold and hysteresis settings. It checks every step against an arithmetic model. This means an off-by-one comparison or a lost hysteresis band is caught at the exact code where the state flips.

// File: rtl/supmon_pkg.sv
// Package: shared types for the supply/temperature supervisor.
// Assumes: nothing beyond standard SystemVerilog.
package supmon_pkg;
    // Which side of the trip point makes a comparator state active.
    typedef enum logic {
        SENSE_BELOW = 1'b0,   // active when the sample is low (supply)
        SENSE_ABOVE = 1'b1    // active when the sample is high (temperature)
    } sense_e;
endpackage

// File: rtl/supmon_hyst_cmp.sv
// Module: hysteretic threshold comparator with a registered state.
// It compares a strobed sample against a trip point and a lower point
// (the trip minus the hysteresis, saturated at zero). SENSE picks whether
// the state is active at the low end or at the high end.
// Assumes: codes are unsigned; the state updates only on strobed edges.
module supmon_hyst_cmp #(
    parameter int                DW      = 12,
    parameter supmon_pkg::sense_e SENSE  = supmon_pkg::SENSE_ABOVE,
    parameter logic              RST_VAL = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld,
    input  logic [DW-1:0] smp,
    input  logic [DW-1:0] trip,
    input  logic [DW-1:0] hyst,
    output logic          active
);
    logic [DW-1:0] lower;
    logic          above;
    logic          below;
    logic          nxt;

    // Lower point of the band, saturated at zero.
    always_comb lower = (hyst > trip) ? '0 : (trip - hyst);

    // Strict comparisons against both points of the band.
    always_comb begin
        above = (smp > trip);
        below = (smp < lower);
    end

    // The next state depends on which side is the active one.
    generate
        if (SENSE == supmon_pkg::SENSE_ABOVE) begin : g_high
            always_comb nxt = above ? 1'b1 : (below ? 1'b0 : active);
        end else begin : g_low
            always_comb nxt = below ? 1'b1 : (above ? 1'b0 : active);
        end
    endgenerate

    // Hold the state; load it only on strobed edges.
    always_ff @(posedge clk) begin
        if (!rst_n)       active <= RST_VAL;
        else if (smp_vld) active <= nxt;
    end

    // R6
    hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(smp_vld) |-> $stable(active));

    // R3 R5
    band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(smp_vld) && ($past(smp) <= $past(trip)) && ($past(smp) >= $past(lower)))
        |-> $stable(active));

    generate
        if (SENSE == supmon_pkg::SENSE_ABOVE) begin : g_chk_high
            // R4
            assert_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(smp_vld) && ($past(smp) > $past(trip))) |-> active);
        end else begin : g_chk_low
            // R2
            release_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(smp_vld) && ($past(smp) > $past(trip))) |-> !active);
        end
    endgenerate
endmodule

// File: rtl/supmon_fault_merge.sv
// Module: merges the fault states into the registered channel disable and
// the registered drive-low enable of the shared open-drain diagnostic.
// Assumes: fault inputs come from registers or synchronized flags.
module supmon_fault_merge #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           uv,
    input  logic           ot,
    input  logic [NCH-1:0] ovc,
    output logic           chan_off,
    output logic           diag_pull
);
    logic [NCH:0] ovc_chain;
    logic         any_ovc;

    // OR the per-channel overcurrent flags together.
    assign ovc_chain[0] = 1'b0;
    generate
        for (genvar c = 0; c < NCH; c++) begin : g_or
            assign ovc_chain[c+1] = ovc_chain[c] | ovc[c];
        end
    endgenerate
    assign any_ovc = ovc_chain[NCH];

    // Register the disable and the diagnostic enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_off  <= 1'b1;
            diag_pull <= 1'b1;
        end else begin
            chan_off  <= uv | ot;
            diag_pull <= uv | ot | any_ovc;
        end
    end

    // R7
    disable_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uv || ot) |=> chan_off);
    // R7
    enable_when_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(uv || ot) |=> !chan_off);
    // R8
    diag_on_ovc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovc != '0) |=> diag_pull);
    // R8
    diag_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!uv && !ot && (ovc == '0)) |=> !diag_pull);
endmodule

// File: rtl/sup_fault_monitor.sv
// Module: top of the supply/temperature fault supervisor.
// It runs one comparator for low supply (active below the band, set at
// reset) and one for overheat (active above the band, clear at reset),
// then merges them with the channel overcurrent flags.
// Assumes: the codes and the strobe are synchronous to clk.
module sup_fault_monitor #(
    parameter int DW  = 12,
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           smp_vld,
    input  logic [DW-1:0]  vsup_code,
    input  logic [DW-1:0]  temp_code,
    input  logic [DW-1:0]  uv_trip_code,
    input  logic [DW-1:0]  uv_hyst_code,
    input  logic [DW-1:0]  ot_trip_code,
    input  logic [DW-1:0]  ot_hyst_code,
    input  logic [NCH-1:0] chan_ovc,
    output logic           uv_active,
    output logic           ot_active,
    output logic           chan_off,
    output logic           diag_pull_low
);
    // Low-supply comparator: active below the band, set at reset.
    supmon_hyst_cmp #(
        .DW(DW), .SENSE(supmon_pkg::SENSE_BELOW), .RST_VAL(1'b1)
    ) u_uv (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(vsup_code),
        .trip(uv_trip_code), .hyst(uv_hyst_code), .active(uv_active)
    );

    // Overheat comparator: active above the band, clear at reset.
    supmon_hyst_cmp #(
        .DW(DW), .SENSE(supmon_pkg::SENSE_ABOVE), .RST_VAL(1'b0)
    ) u_ot (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(temp_code),
        .trip(ot_trip_code), .hyst(ot_hyst_code), .active(ot_active)
    );

    // Merge the fault states and the overcurrent flags.
    supmon_fault_merge #(.NCH(NCH)) u_merge (
        .clk(clk), .rst_n(rst_n), .uv(uv_active), .ot(ot_active),
        .ovc(chan_ovc), .chan_off(chan_off), .diag_pull(diag_pull_low)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (uv_active && !ot_active && chan_off && diag_pull_low));
endmodule

// File: tb/sup_fault_monitor_bench.sv
module sup_fault_monitor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW  = 12;
    localparam int NCH = 4;
    localparam int WD_CYCLES = 190000;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           smp_vld;
    logic [DW-1:0]  vsup_code, temp_code;
    logic [DW-1:0]  uv_trip_code, uv_hyst_code, ot_trip_code, ot_hyst_code;
    logic [NCH-1:0] chan_ovc;
    logic           uv_active, ot_active, chan_off, diag_pull_low;
    logic           diag_line;

    int n_vec  = 0;
    int n_fail = 0;
    logic m_uv, m_ot;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Open-drain line with an external pull-up.
    assign diag_line = diag_pull_low ? 1'b0 : 1'b1;

    sup_fault_monitor #(.DW(DW), .NCH(NCH)) u_sup_fault_monitor (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
        .vsup_code(vsup_code), .temp_code(temp_code),
        .uv_trip_code(uv_trip_code), .uv_hyst_code(uv_hyst_code),
        .ot_trip_code(ot_trip_code), .ot_hyst_code(ot_hyst_code),
        .chan_ovc(chan_ovc), .uv_active(uv_active), .ot_active(ot_active),
        .chan_off(chan_off), .diag_pull_low(diag_pull_low)
    );

    function automatic int low_pt(int trip, int hyst);
        return (hyst > trip) ? 0 : trip - hyst;
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic cfg(int ut, int uh, int tt, int th);
        uv_trip_code = DW'(ut); uv_hyst_code = DW'(uh);
        ot_trip_code = DW'(tt); ot_hyst_code = DW'(th);
    endtask

    // One strobed sample, then check the states and the merged outputs.
    task automatic step(int v, int t);
        @(negedge clk);
        smp_vld = 1'b1; vsup_code = DW'(v); temp_code = DW'(t);
        if (v > uv_trip_code) m_uv = 1'b0;
        else if (v < low_pt(uv_trip_code, uv_hyst_code)) m_uv = 1'b1;
        if (t > ot_trip_code) m_ot = 1'b1;
        else if (t < low_pt(ot_trip_code, ot_hyst_code)) m_ot = 1'b0;
        @(negedge clk);
        smp_vld = 1'b0;
        chk("R2,R3,R10 uv_active", uv_active, m_uv);
        chk("R4,R5,R10 ot_active", ot_active, m_ot);
        @(negedge clk);
        chk("R7 chan_off", chan_off, m_uv | m_ot);
        chk("R8 diag_line", diag_line, !(m_uv | m_ot | (chan_ovc != '0)));
    endtask

    task automatic sweep();
        for (int i = 0; i < (1 << DW); i++) step(i, i);
        for (int i = (1 << DW) - 1; i >= 0; i--) step(i, i);
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; smp_vld = 1'b0; vsup_code = '0; temp_code = '0;
        chan_ovc = '0;
        cfg(2000, 150, 3000, 300);
        m_uv = 1'b1; m_ot = 1'b0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 uv_active", uv_active, 1'b1);
        chk("R1 ot_active", ot_active, 1'b0);
        chk("R1 chan_off", chan_off, 1'b1);
        chk("R1 diag_line", diag_line, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 chan_off after release", chan_off, 1'b1);

        // Boundary: equal to trip neither clears low-supply nor sets overheat.
        step(2000, 3000);
        chk("R2 equal trip keeps uv", uv_active, 1'b1);
        chk("R4 equal trip keeps ot clear", ot_active, 1'b0);

        // Wide ramps: config A, then R6 with codes that would flip the states.
        sweep();
        @(negedge clk);
        vsup_code = DW'(4095); temp_code = DW'(4095);
        repeat (3) @(negedge clk);
        chk("R6 uv unchanged without strobe", uv_active, 1'b1);
        chk("R6 ot unchanged without strobe", ot_active, 1'b0);
        chk("R6 chan_off unchanged without strobe", chan_off, 1'b1);

        // R8: each overcurrent flag alone pulls the line, but not the disable.
        step(4095, 0);
        for (int c = 0; c < NCH; c++) begin
            @(negedge clk);
            chan_ovc = NCH'(1) << c;
            @(negedge clk);
            chk("R8 ovc pulls line", diag_line, 1'b0);
            chk("R7 ovc leaves chan_off", chan_off, 1'b0);
            chan_ovc = '0;
            @(negedge clk);
            chk("R8 line released", diag_line, 1'b1);
        end

        // Config B: narrow and zero hysteresis near the code edges.
        cfg(5, 3, 4090, 0);
        sweep();

        // Config C: hysteresis wider than trip, lower point saturates (R9).
        cfg(100, 200, 50, 80);
        sweep();
        chk("R9 uv never reasserts", uv_active, 1'b0);
        chk("R9 ot never clears", ot_active, 1'b1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule